// File: doc/BRIEF.md
# External Interrupt Sampling and Gating Unit

This unit watches six asynchronous external interrupt pins and one power-fail request. It turns them into pending flags and enabled requests for a CPU sequencer. Each pin passes through a two-flop synchronizer. A sample strobe then looks at it once per machine cycle. The strobe generator sets the length of the machine cycle from the current power-management mode.

Two of the pins can work either as level sources or as pseudo-edge sources. The other four are edge-only, and their polarities are mixed. Every flag is normalized, so 1 always means pending. Each request is gated by its own enable and by a global enable. The power-fail request is the exception: it is gated by its own enable only.

The sequencer acknowledges an edge request, which clears that flag and marks the CPU as busy. A return-from-interrupt pulse ends the busy state. While the CPU is busy, the level sources are not sampled.

Top module: `ext_irq_gate`

## Requirements
- R1: The strobe `mc_strobe_o` is high for one clock in every machine cycle.
  - The cycle length is 4 clocks when `pm_mode_i`=0, 64 clocks when it is 1, and 1024 clocks when it is 2 or 3.
- R2: Pins are sampled only on a strobe cycle.
  - A pin change reaches the flags at the first strobe that comes after two synchronizer clocks.
  - Before that strobe the flag does not change.
- R3: `pin_i[0]` and `pin_i[1]` are active low.
  - Bit `trig_edge_i[k]` (k=0,1) selects edge detection when 1 and level detection when 0.
  - For pins 2 to 5 the bit is ignored.
- R4: In level mode, `flag_o[k]` follows the last sampled active state of the pin. It is not latched: it returns to 0 once an inactive sample is taken.
- R5: In edge mode, a flag is set when an inactive sample is followed by an active sample.
  - `pin_i[2]` and `pin_i[4]` are active high; `pin_i[3]` and `pin_i[5]` are active low.
  - A pin held active does not set the flag again after it has been cleared.
- R6: A flag value of 1 means pending, whatever the pin polarity. A pin held active through reset produces no edge.
- R7: While `glb_en_i`=0, `req_o[5:0]` is 0. The power-fail request `req_o[6]` ignores `glb_en_i`.
- R8: An acknowledge makes the unit busy until `reti_i` is pulsed. While busy, level-mode flags keep their value and are not resampled.
- R9: `ack_i[k]` or a software clear (`sw_clr_i` with `sw_clr_mask_i[k]`) clears edge flag k. If a new edge sets the flag in the same cycle, the set wins.
- R10: `req_o[k]` is 1 exactly when flag k is set, `src_en_i[k]`=1 and `glb_en_i`=1. `req_o[6]` is the sampled power-fail request ANDed with `src_en_i[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Raw external interrupt pins |
| pf_req_i | input | 1 | Raw power-fail request, active high |
| pm_mode_i | input | 2 | Power-management mode (0 run, 1 slow, 2/3 slowest) |
| trig_edge_i | input | 6 | Edge select per pin (only bits 0 and 1 are used) |
| glb_en_i | input | 1 | Global enable for the pin requests |
| src_en_i | input | 7 | Individual enables; bit 6 is power-fail |
| ack_i | input | 6 | Acknowledge pulse per pin |
| reti_i | input | 1 | Return-from-interrupt pulse |
| sw_clr_i | input | 1 | Software flag-clear strobe |
| sw_clr_mask_i | input | 6 | Flags cleared by the software strobe |
| mc_strobe_o | output | 1 | Machine-cycle sample strobe |
| flag_o | output | 6 | Pending flags (1 = pending) |
| req_o | output | 7 | Enabled requests to the sequencer; bit 6 is power-fail |

## Verification
A new edge detection and a clear of the same flag can land in one clock. That happens when the sample strobe that sees an inactive-to-active transition coincides with an acknowledge for that pin. The bench provokes it by tracking the strobe output at falling clock edges and raising `ack_i[5]` on exactly the cycle in which the strobe samples the new active level of pin 5. After that edge the flag must still read 1, since the set wins. A later acknowledge with no edge pending must clear it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Oscillator clocks per machine cycle for a power-management mode.
  function automatic logic [31:0] mc_period(input logic [1:0] mode,
                                            input logic [31:0] run_clks,
                                            input logic [31:0] slow1_clks,
                                            input logic [31:0] slow2_clks);
    case (mode)
      2'd0:    return run_clks;
      2'd1:    return slow1_clks;
      default: return slow2_clks;
    endcase
  endfunction

  // Converts a raw pin level into "1 = asserted".
  function automatic logic norm_active(input logic raw, input logic act_low);
    return raw ^ act_low;
  endfunction

endpackage

// File: rtl/irq_mc_strobe.sv
module irq_mc_strobe
  import ext_irq_pkg::*;
#(
  parameter int unsigned RUN_CLKS   = 4,
  parameter int unsigned SLOW1_CLKS = 64,
  parameter int unsigned SLOW2_CLKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pm_mode,
  output logic       stb
);
  localparam int unsigned CNT_W = $clog2(RUN_CLKS + SLOW1_CLKS + SLOW2_CLKS) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      per;

  assign per = mc_period(pm_mode, RUN_CLKS, SLOW1_CLKS, SLOW2_CLKS);
  assign stb = (32'(cnt_q) >= per - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (stb) cnt_q <= '0;
    else          cnt_q <= cnt_q + CNT_W'(1);
  end

  // Checker: gap between strobes at a steady mode equals the mode period.
  logic [CNT_W-1:0] gap_q;
  logic [1:0]       mode_q;
  logic             seen_q, clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      mode_q  <= '0;
      seen_q  <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      mode_q <= pm_mode;
      gap_q  <= stb ? '0 : gap_q + CNT_W'(1);
      if (stb) seen_q <= 1'b1;
      if (pm_mode != mode_q) clean_q <= 1'b0;
      else if (stb)          clean_q <= 1'b1;
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && seen_q && clean_q && pm_mode == mode_q) |-> (32'(gap_q) == per - 32'd1));

endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned        W       = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= RST_VAL;
    else        st_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= RST_VAL;
      else        st_q[s] <= st_q[s-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter bit LEVEL_OK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic busy,
  input  logic act,
  input  logic trig_edge,
  input  logic ack,
  input  logic sw_clr,
  output logic flag,
  output logic edge_set
);
  logic level_mode;
  logic prev_q, lvl_q, eflag_q;
  logic clr;

  assign level_mode = LEVEL_OK && !trig_edge;
  assign edge_set   = stb && act && !prev_q && !level_mode;
  assign clr        = ack || sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;   // treat as already active: no false edge after reset
      lvl_q   <= 1'b0;
      eflag_q <= 1'b0;
    end else begin
      if (stb)          prev_q <= act;
      if (stb && !busy) lvl_q  <= act;
      if (edge_set)     eflag_q <= 1'b1;
      else if (clr)     eflag_q <= 1'b0;
    end
  end

  assign flag = level_mode ? lvl_q : eflag_q;

  p_edge_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eflag_q) |-> $past(stb));
  p_level_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lvl_q));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_set |=> eflag_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_set) |=> !eflag_q);

endmodule

// File: rtl/ext_irq_gate.sv
module ext_irq_gate
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_PINS       = 6,
  parameter logic [5:0]  ACT_LOW_MASK = 6'b101011,
  parameter logic [5:0]  LEVEL_MASK   = 6'b000011,
  parameter int unsigned RUN_CLKS     = 4,
  parameter int unsigned SLOW1_CLKS   = 64,
  parameter int unsigned SLOW2_CLKS   = 1024,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              pf_req_i,
  input  logic [1:0]        pm_mode_i,
  input  logic [N_PINS-1:0] trig_edge_i,
  input  logic              glb_en_i,
  input  logic [N_PINS:0]   src_en_i,
  input  logic [N_PINS-1:0] ack_i,
  input  logic              reti_i,
  input  logic              sw_clr_i,
  input  logic [N_PINS-1:0] sw_clr_mask_i,
  output logic              mc_strobe_o,
  output logic [N_PINS-1:0] flag_o,
  output logic [N_PINS:0]   req_o
);
  localparam int unsigned PF = N_PINS;

  logic              stb;
  logic [N_PINS-1:0] act_raw, act_s, edge_set;
  logic              pf_s, pf_q, busy_q;

  irq_mc_strobe #(
    .RUN_CLKS(RUN_CLKS), .SLOW1_CLKS(SLOW1_CLKS), .SLOW2_CLKS(SLOW2_CLKS)
  ) i_strobe (
    .clk(clk), .rst_n(rst_n), .pm_mode(pm_mode_i), .stb(stb)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_norm
    assign act_raw[i] = norm_active(pin_i[i], ACT_LOW_MASK[i]);
  end

  irq_sync #(.W(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL({N_PINS{1'b1}})) i_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(act_raw), .q(act_s)
  );

  irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pf_sync (
    .clk(clk), .rst_n(rst_n), .d(pf_req_i), .q(pf_s)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_det
    irq_detect #(.LEVEL_OK(LEVEL_MASK[i])) i_det (
      .clk(clk), .rst_n(rst_n), .stb(stb), .busy(busy_q),
      .act(act_s[i]), .trig_edge(trig_edge_i[i]), .ack(ack_i[i]),
      .sw_clr(sw_clr_i && sw_clr_mask_i[i]),
      .flag(flag_o[i]), .edge_set(edge_set[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (stb)         pf_q   <= pf_s;
      if (|ack_i)      busy_q <= 1'b1;
      else if (reti_i) busy_q <= 1'b0;
    end
  end

  assign req_o[N_PINS-1:0] = flag_o & src_en_i[N_PINS-1:0] & {N_PINS{glb_en_i}};
  assign req_o[PF]         = pf_q & src_en_i[PF];
  assign mc_strobe_o       = stb;

  p_global_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> (req_o[N_PINS-1:0] == '0));
  p_busy_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(|ack_i));
  p_pf_sampled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(pf_q));

endmodule

// File: tb/test_ext_irq_gate.sv
module test_ext_irq_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin_i = 6'b101111;  // pin2 held active through reset
  logic       pf_req_i = 1'b0;
  logic [1:0] pm_mode_i = 2'd0;
  logic [5:0] trig_edge_i = 6'b111111;
  logic       glb_en_i = 1'b1;
  logic [6:0] src_en_i = 7'h7f;
  logic [5:0] ack_i = '0;
  logic       reti_i = 1'b0;
  logic       sw_clr_i = 1'b0;
  logic [5:0] sw_clr_mask_i = '0;
  logic       mc_strobe_o;
  logic [5:0] flag_o;
  logic [6:0] req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_gate i_ext_irq_gate (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned ref_period(input logic [1:0] m);
    return (m == 2'd3) ? 1024 : (4 << (4 * m));
  endfunction

  task automatic find_strobe();
    @(negedge clk);
    while (!mc_strobe_o) @(negedge clk);
  endtask

  // Wait until a pin change has passed the synchronizer and one strobe sample.
  task automatic wait_sample();
    repeat (2) @(posedge clk);
    find_strobe();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_ack(input logic [5:0] m);
    @(negedge clk); ack_i = m;
    @(negedge clk); ack_i = '0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(flag_o, 0, "R6 flags clear in reset");
    chk(req_o, 0, "R10 requests clear in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) wait_sample();
    chk(flag_o[2], 0, "R6 pin held active through reset gives no edge");
  endtask

  task automatic t_period(input logic [1:0] m);
    int unsigned n;
    pm_mode_i = m;
    find_strobe();
    find_strobe();
    n = 0;
    do begin @(negedge clk); n++; end while (!mc_strobe_o);
    chk(n, ref_period(m), "R1 machine cycle length");
    pm_mode_i = 2'd0;
    find_strobe();
    find_strobe();
  endtask

  task automatic t_edge_high();
    pin_i[2] = 1'b0; wait_sample();
    chk(flag_o[2], 0, "R5 inactive sample leaves flag clear");
    pin_i[2] = 1'b1;
    repeat (2) @(posedge clk);
    find_strobe();
    chk(flag_o[2], 0, "R2 flag unchanged before sample strobe");
    @(posedge clk); #1;
    chk(flag_o[2], 1, "R5 active-high rising edge sets flag");
    chk(req_o[2], 1, "R10 enabled request follows flag");
    pulse_ack(6'b000100);
    chk(flag_o[2], 0, "R9 acknowledge clears edge flag");
    pulse_reti();
  endtask

  task automatic t_edge_low();
    pin_i[3] = 1'b0; wait_sample();
    chk(flag_o[3], 1, "R5 active-low falling edge sets flag");
    pulse_ack(6'b001000);
    repeat (3) wait_sample();
    chk(flag_o[3], 0, "R5 held-active pin does not retrigger");
    pulse_reti();
  endtask

  task automatic t_level();
    trig_edge_i[0] = 1'b0;
    pin_i[0] = 1'b0; wait_sample();
    chk(flag_o[0], 1, "R4 level flag set while pin low");
    pin_i[0] = 1'b1; wait_sample();
    chk(flag_o[0], 0, "R4 level flag not latched");
  endtask

  task automatic t_busy();
    pin_i[0] = 1'b0; wait_sample();
    chk(flag_o[0], 1, "R8 level active before service");
    pulse_ack(6'b000001);
    pin_i[0] = 1'b1;
    wait_sample(); wait_sample();
    chk(flag_o[0], 1, "R8 level sample frozen while busy");
    pulse_reti();
    wait_sample();
    chk(flag_o[0], 0, "R8 level resampled after return");
  endtask

  task automatic t_int1_mode();
    pin_i[1] = 1'b0; wait_sample();
    chk(flag_o[1], 1, "R3 pin1 edge mode sets flag on low");
    pulse_ack(6'b000010);
    wait_sample();
    chk(flag_o[1], 0, "R3 pin1 edge flag stays clear");
    pulse_reti();
    trig_edge_i[1] = 1'b0;
    wait_sample();
    chk(flag_o[1], 1, "R3 pin1 level mode reflects low pin");
    pin_i[1] = 1'b1; wait_sample();
    trig_edge_i[1] = 1'b1;
  endtask

  task automatic t_collide();
    pin_i[5] = 1'b0; wait_sample();
    chk(flag_o[5], 1, "R5 pin5 falling edge sets flag");
    pin_i[5] = 1'b1; wait_sample();
    pin_i[5] = 1'b0;
    repeat (2) @(posedge clk);
    find_strobe();
    ack_i = 6'b100000;
    @(posedge clk); #1;
    chk(flag_o[5], 1, "R9 set wins over same-cycle acknowledge");
    @(negedge clk); ack_i = '0;
    pulse_ack(6'b100000);
    chk(flag_o[5], 0, "R9 lone acknowledge clears");
    pulse_reti();
  endtask

  task automatic t_sw_clear();
    pin_i[4] = 1'b1; wait_sample();
    chk(flag_o[4], 1, "R5 pin4 rising edge sets flag");
    @(negedge clk); sw_clr_i = 1'b1; sw_clr_mask_i = 6'b010000;
    @(negedge clk); sw_clr_i = 1'b0; sw_clr_mask_i = '0;
    chk(flag_o[4], 0, "R9 software clear");
  endtask

  task automatic t_gating();
    pin_i[3] = 1'b1; wait_sample();
    pin_i[3] = 1'b0; wait_sample();
    chk(flag_o[3], 1, "R5 pin3 new edge");
    glb_en_i = 1'b0; #1;
    chk(req_o[5:0], 0, "R7 global enable off blocks pin requests");
    glb_en_i = 1'b1; #1;
    chk(req_o[3], 1, "R10 request with both enables");
    src_en_i[3] = 1'b0; #1;
    chk(req_o[3], 0, "R10 individual enable off");
    src_en_i[3] = 1'b1;
    glb_en_i = 1'b0;
    pf_req_i = 1'b1; wait_sample();
    chk(req_o[6], 1, "R7 power-fail bypasses global enable");
    src_en_i[6] = 1'b0; #1;
    chk(req_o[6], 0, "R10 power-fail individual enable");
    src_en_i[6] = 1'b1;
    glb_en_i = 1'b1;
  endtask

  initial begin
    t_reset();
    t_period(2'd0);
    t_period(2'd1);
    t_period(2'd2);
    t_period(2'd3);
    t_edge_high();
    t_edge_low();
    t_level();
    t_busy();
    t_int1_mode();
    t_collide();
    t_sw_clear();
    t_gating();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule